// File: doc/BRIEF.md
# Byte-Stream Command to Register Bus Bridge

This block sits between a byte-oriented serial receiver and a simple register bus. It collects framed command packets one byte at a time, checks their framing, and turns each good command into exactly one 32-bit register read or write on a bus with a 16-bit address. When the bus access is done, it builds a framed reply and hands it, one byte at a time, to a downstream transmitter.

Commands open with 0x55 and close with 0xAA. Replies use the opposite markers: they open with 0xAA and close with 0x55. Each command kind has its own reply code. Malformed frames and unknown opcodes get their own error codes and are never dropped without a reply. A reset command pulses a one-cycle soft-reset output.

The control core is one state machine with these states:
- `ST_IDLE` waits for the start marker.
- `ST_OPCODE` classifies the command.
- `ST_ADDR` shifts in the address bytes.
- `ST_WDATA` shifts in the write-data bytes.
- `ST_TAIL` checks the end marker.
- `ST_SKIP` discards the body of an unknown opcode.
- `ST_BUS` holds the bus request.
- `ST_REPLY` waits while the reply is sent.

Transitions:
- `ST_IDLE` goes to `ST_OPCODE` on 0x55.
- `ST_OPCODE` goes to `ST_ADDR` for a read or write, to `ST_TAIL` for a reset, and to `ST_SKIP` for any other opcode.
- `ST_ADDR` goes to `ST_WDATA` (write) or `ST_TAIL` (read) after the last address byte.
- `ST_WDATA` goes to `ST_TAIL` after the last data byte.
- `ST_TAIL` goes to `ST_BUS` on a good marker for a read or write. It goes to `ST_REPLY` for a reset or for a bad marker.
- `ST_SKIP` goes to `ST_REPLY` on 0xAA.
- `ST_BUS` goes to `ST_REPLY` when the bus is ready.
- `ST_REPLY` goes to `ST_IDLE` once the last reply byte is accepted.

Top module: `cmd_bus_bridge`

## Requirements
- R1: While idle, any received byte other than 0x55 (including 0xAA) is discarded: it causes no bus access and no reply.
- R2: A read frame is 0x55, opcode 0x10, address high byte, address low byte, 0xAA. It issues one bus access with `bus_we` low and `bus_addr` = {high, low}. `bus_cs` is high in the cycle right after the end-marker byte is taken.
- R3: A completed read replies 0xAA, 0x7F, address high, address low, then the four read-data bytes most significant first, then 0x55. The read data is the `bus_rdata` value sampled in the cycle `bus_ready` is high.
- R4: A write frame is 0x55, opcode 0x11, two address bytes, four data bytes most significant first, 0xAA. It issues one bus access with `bus_we` high and that address and data. It replies 0xAA, 0x7E, address high, address low, 0x55.
- R5: The bus request (`bus_cs`, `bus_we`, `bus_addr`, `bus_wdata`) stays asserted and unchanged until `bus_ready` is seen. No reply byte is offered before then.
- R6: If the byte where the end marker belongs is not 0xAA, no bus access is issued and the reply is 0xAA, 0xFD, 0x55.
- R7: An opcode other than 0x10, 0x11 or 0x01 causes the following bytes to be skipped up to and including the next 0xAA. The reply is then 0xAA, 0xFE, 0x55, with no bus access.
- R8: The reset command 0x55, 0x01, 0xAA pulses `soft_rst` high for exactly one cycle, starting the cycle after the end marker is taken. It replies 0xAA, 0x7D, 0x55, with no bus access.
- R9: `tx_valid` with `tx_data` is held unchanged while `tx_ready` is low. Exactly one reply byte is consumed per cycle in which both are high, in frame order.
- R10: Bytes received while a command is on the bus or its reply is being sent are ignored. They start no bus access and no reply.
- R11: Out of reset, `bus_cs`, `tx_valid` and `soft_rst` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte is present this cycle |
| tx_data | output | 8 | Reply byte offered to the transmitter |
| tx_valid | output | 1 | Reply byte is valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| bus_cs | output | 1 | Bus request active |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 16 | Register address, core prefix in the high byte |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled when bus_ready is high |
| bus_ready | input | 1 | Bus access completes this cycle |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
`bus_cs` is due one cycle after the end-marker byte is taken. `soft_rst` is due in that same cycle and must be gone the cycle after. The first reply byte comes two cycles after the cycle in which `bus_ready` is high, or after the end-marker byte for a reset or error reply. Each later byte follows one handshake after the one before.

The bench samples on the falling edge. It checks `bus_cs` and `soft_rst` on the first falling edge after the end byte's rising edge. For a slow bus, it checks on every falling edge before `bus_ready` that no reply byte is offered. Reply bytes are compared in order against a scoreboard queue whenever a handshake is due. This holds whatever number of cycles the readiness pattern inserts.

// File: rtl/bbr_pkg.sv
`timescale 1ns/1ps
package bbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_TAIL,
        ST_SKIP,
        ST_BUS,
        ST_REPLY
    } bbr_state_e;

    typedef enum logic [1:0] {
        CK_READ,
        CK_WRITE,
        CK_RESET
    } cmd_kind_e;

    // Reply layout: code only, code plus address, code plus address plus data
    typedef enum logic [1:0] {
        RF_CODE,
        RF_ADDR,
        RF_FULL
    } reply_fmt_e;

    localparam logic [7:0] CMD_SOF      = 8'h55;
    localparam logic [7:0] CMD_EOF      = 8'hAA;
    localparam logic [7:0] RSP_SOF      = 8'hAA;
    localparam logic [7:0] RSP_EOF      = 8'h55;

    localparam logic [7:0] OPC_READ     = 8'h10;
    localparam logic [7:0] OPC_WRITE    = 8'h11;
    localparam logic [7:0] OPC_RESET    = 8'h01;

    localparam logic [7:0] RC_READ_OK   = 8'h7F;
    localparam logic [7:0] RC_WRITE_OK  = 8'h7E;
    localparam logic [7:0] RC_RESET_OK  = 8'h7D;
    localparam logic [7:0] RC_BAD_OPC   = 8'hFE;
    localparam logic [7:0] RC_BAD_FRAME = 8'hFD;

endpackage

// File: rtl/bbr_reply_pack.sv
`timescale 1ns/1ps
// Assembles a reply frame from code, format, address and read data.
module bbr_reply_pack
    import bbr_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int DATA_BYTES = 4,
    parameter int MAXB       = 3 + ADDR_BYTES + DATA_BYTES,
    parameter int LEN_W      = $clog2(MAXB + 1)
) (
    input  logic [7:0]                code,
    input  reply_fmt_e                fmt,
    input  logic [ADDR_BYTES*8-1:0]   addr,
    input  logic [DATA_BYTES*8-1:0]   data,
    output logic [MAXB-1:0][7:0]      frame,
    output logic [LEN_W-1:0]          len
);

    localparam int N_CODE = 2;
    localparam int N_ADDR = 2 + ADDR_BYTES;
    localparam int N_FULL = 2 + ADDR_BYTES + DATA_BYTES;

    int tail_pos;

    always_comb begin
        unique case (fmt)
            RF_ADDR: tail_pos = N_ADDR;
            RF_FULL: tail_pos = N_FULL;
            default: tail_pos = N_CODE;
        endcase
    end

    always_comb begin
        frame    = '0;
        frame[0] = RSP_SOF;
        frame[1] = code;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (fmt != RF_CODE)
                frame[2 + i] = addr[(ADDR_BYTES - 1 - i) * 8 +: 8];
        end
        for (int j = 0; j < DATA_BYTES; j++) begin
            if (fmt == RF_FULL)
                frame[2 + ADDR_BYTES + j] = data[(DATA_BYTES - 1 - j) * 8 +: 8];
        end
        for (int k = 0; k < MAXB; k++) begin
            if (k == tail_pos)
                frame[k] = RSP_EOF;
        end
        len = LEN_W'(tail_pos + 1);
    end

endmodule

// File: rtl/bbr_reply_ser.sv
`timescale 1ns/1ps
// Holds a loaded reply frame and offers it one byte per handshake.
module bbr_reply_ser #(
    parameter int MAXB  = 9,
    parameter int LEN_W = $clog2(MAXB + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [MAXB-1:0][7:0]  frame,
    input  logic [LEN_W-1:0]      len,
    input  logic                  tx_ready,
    output logic [7:0]            tx_data,
    output logic                  tx_valid,
    output logic                  done
);

    logic [MAXB-1:0][7:0] hold_q;
    logic [LEN_W-1:0]     len_q;
    logic [LEN_W-1:0]     idx_q;
    logic                 valid_q;
    logic                 at_last;

    assign at_last = (idx_q == (len_q - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            hold_q  <= frame;
            len_q   <= len;
            idx_q   <= '0;
            valid_q <= 1'b1;
        end else if (valid_q && tx_ready) begin
            if (at_last)
                valid_q <= 1'b0;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        tx_valid = valid_q;
        tx_data  = hold_q[idx_q];
        done     = valid_q && tx_ready && at_last;
    end

endmodule

// File: rtl/bbr_cmd_fsm.sv
`timescale 1ns/1ps
// Parses command frames, drives the register bus and requests replies.
module bbr_cmd_fsm
    import bbr_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int DATA_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               rx_data,
    input  logic                     rx_valid,
    output logic                     bus_cs,
    output logic                     bus_we,
    output logic [ADDR_BYTES*8-1:0]  bus_addr,
    output logic [DATA_BYTES*8-1:0]  bus_wdata,
    input  logic [DATA_BYTES*8-1:0]  bus_rdata,
    input  logic                     bus_ready,
    output logic                     soft_rst,
    output logic                     reply_go,
    output logic [7:0]               reply_code,
    output reply_fmt_e               reply_fmt,
    output logic [ADDR_BYTES*8-1:0]  reply_addr,
    output logic [DATA_BYTES*8-1:0]  reply_data,
    input  logic                     reply_done
);

    localparam int AW    = ADDR_BYTES * 8;
    localparam int DW    = DATA_BYTES * 8;
    localparam int MAXF  = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
    localparam int CNT_W = $clog2(MAXF) + 1;
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BYTES - 1);

    bbr_state_e        state, state_n;
    cmd_kind_e         kind_q, kind_n;
    reply_fmt_e        fmt_q, fmt_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [7:0]        code_q, code_n;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rdata_q;
    logic              go_q, srst_q;
    logic              addr_shift, data_shift, cap_rdata, enter_reply, srst_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Next state and datapath strobes
    always_comb begin
        state_n     = state;
        kind_n      = kind_q;
        fmt_n       = fmt_q;
        cnt_n       = cnt_q;
        code_n      = code_q;
        addr_shift  = 1'b0;
        data_shift  = 1'b0;
        cap_rdata   = 1'b0;
        enter_reply = 1'b0;
        srst_n      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (rx_valid && rx_data == CMD_SOF)
                    state_n = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (rx_valid) begin
                    cnt_n = '0;
                    if (rx_data == OPC_READ) begin
                        kind_n  = CK_READ;
                        state_n = ST_ADDR;
                    end else if (rx_data == OPC_WRITE) begin
                        kind_n  = CK_WRITE;
                        state_n = ST_ADDR;
                    end else if (rx_data == OPC_RESET) begin
                        kind_n  = CK_RESET;
                        state_n = ST_TAIL;
                    end else begin
                        state_n = ST_SKIP;
                    end
                end
            end
            ST_ADDR: begin
                if (rx_valid) begin
                    addr_shift = 1'b1;
                    if (cnt_q == ADDR_LAST) begin
                        cnt_n   = '0;
                        state_n = (kind_q == CK_WRITE) ? ST_WDATA : ST_TAIL;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                if (rx_valid) begin
                    data_shift = 1'b1;
                    if (cnt_q == DATA_LAST) begin
                        cnt_n   = '0;
                        state_n = ST_TAIL;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (rx_valid) begin
                    if (rx_data != CMD_EOF) begin
                        code_n      = RC_BAD_FRAME;
                        fmt_n       = RF_CODE;
                        enter_reply = 1'b1;
                        state_n     = ST_REPLY;
                    end else if (kind_q == CK_RESET) begin
                        srst_n      = 1'b1;
                        code_n      = RC_RESET_OK;
                        fmt_n       = RF_CODE;
                        enter_reply = 1'b1;
                        state_n     = ST_REPLY;
                    end else begin
                        state_n = ST_BUS;
                    end
                end
            end
            ST_SKIP: begin
                if (rx_valid && rx_data == CMD_EOF) begin
                    code_n      = RC_BAD_OPC;
                    fmt_n       = RF_CODE;
                    enter_reply = 1'b1;
                    state_n     = ST_REPLY;
                end
            end
            ST_BUS: begin
                if (bus_ready) begin
                    cap_rdata   = 1'b1;
                    code_n      = (kind_q == CK_WRITE) ? RC_WRITE_OK : RC_READ_OK;
                    fmt_n       = (kind_q == CK_WRITE) ? RF_ADDR : RF_FULL;
                    enter_reply = 1'b1;
                    state_n     = ST_REPLY;
                end
            end
            ST_REPLY: begin
                if (reply_done)
                    state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= CK_READ;
            fmt_q   <= RF_CODE;
            cnt_q   <= '0;
            code_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            go_q    <= 1'b0;
            srst_q  <= 1'b0;
        end else begin
            kind_q <= kind_n;
            fmt_q  <= fmt_n;
            cnt_q  <= cnt_n;
            code_q <= code_n;
            go_q   <= enter_reply;
            srst_q <= srst_n;
            if (addr_shift)
                addr_q <= (addr_q << 8) | AW'(rx_data);
            if (data_shift)
                wdata_q <= (wdata_q << 8) | DW'(rx_data);
            if (cap_rdata)
                rdata_q <= bus_rdata;
        end
    end

    // Outputs
    always_comb begin
        bus_cs     = (state == ST_BUS);
        bus_we     = (state == ST_BUS) && (kind_q == CK_WRITE);
        bus_addr   = addr_q;
        bus_wdata  = wdata_q;
        soft_rst   = srst_q;
        reply_go   = go_q;
        reply_code = code_q;
        reply_fmt  = fmt_q;
        reply_addr = addr_q;
        reply_data = rdata_q;
    end

endmodule

// File: rtl/cmd_bus_bridge.sv
`timescale 1ns/1ps
module cmd_bus_bridge
    import bbr_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int DATA_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               rx_data,
    input  logic                     rx_valid,
    output logic [7:0]               tx_data,
    output logic                     tx_valid,
    input  logic                     tx_ready,
    output logic                     bus_cs,
    output logic                     bus_we,
    output logic [ADDR_BYTES*8-1:0]  bus_addr,
    output logic [DATA_BYTES*8-1:0]  bus_wdata,
    input  logic [DATA_BYTES*8-1:0]  bus_rdata,
    input  logic                     bus_ready,
    output logic                     soft_rst
);

    localparam int AW    = ADDR_BYTES * 8;
    localparam int DW    = DATA_BYTES * 8;
    localparam int MAXB  = 3 + ADDR_BYTES + DATA_BYTES;
    localparam int LEN_W = $clog2(MAXB + 1);

    logic                 reply_go, reply_done;
    logic [7:0]           reply_code;
    reply_fmt_e           reply_fmt;
    logic [AW-1:0]        reply_addr;
    logic [DW-1:0]        reply_data;
    logic [MAXB-1:0][7:0] reply_frame;
    logic [LEN_W-1:0]     reply_len;

    bbr_cmd_fsm #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .bus_cs     (bus_cs),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ready  (bus_ready),
        .soft_rst   (soft_rst),
        .reply_go   (reply_go),
        .reply_code (reply_code),
        .reply_fmt  (reply_fmt),
        .reply_addr (reply_addr),
        .reply_data (reply_data),
        .reply_done (reply_done)
    );

    bbr_reply_pack #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES),
        .MAXB       (MAXB),
        .LEN_W      (LEN_W)
    ) u_pack (
        .code  (reply_code),
        .fmt   (reply_fmt),
        .addr  (reply_addr),
        .data  (reply_data),
        .frame (reply_frame),
        .len   (reply_len)
    );

    bbr_reply_ser #(
        .MAXB  (MAXB),
        .LEN_W (LEN_W)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reply_go),
        .frame    (reply_frame),
        .len      (reply_len),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .done     (reply_done)
    );

endmodule

// File: rtl/bbr_checker.sv
`timescale 1ns/1ps
module bbr_checker #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ready,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          soft_rst
);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs && !bus_ready |=> bus_cs && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_req_ends_on_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs) |-> $past(bus_ready));

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    assert_reply_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_data == 8'hAA);

    assert_srst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && tx_valid));

endmodule

bind cmd_bus_bridge bbr_checker #(
    .AW (ADDR_BYTES * 8),
    .DW (DATA_BYTES * 8)
) u_bbr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .soft_rst  (soft_rst)
);

// File: tb/tb_cmd_bus_bridge.sv
`timescale 1ns/1ps
module tb_cmd_bus_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        bus_cs, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready;
    logic        soft_rst;

    always #5 clk = ~clk;

    cmd_bus_bridge dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .soft_rst(soft_rst)
    );

    int    checks = 0;
    int    errors = 0;
    int    bus_lat = 0;
    int    bus_seen = 0;
    int    ready_mode = 0;
    string cur_tag = "R11";
    bit    finished = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    // Scoreboard queues
    logic [7:0]  exp_tx[$];
    string       exp_tx_tag[$];
    logic        exp_we[$];
    logic [15:0] exp_addr[$];
    logic [31:0] exp_wd[$];
    logic [31:0] exp_rd[$];
    string       exp_bus_tag[$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_tx(input logic [71:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_tx.push_back(v[(n - 1 - i) * 8 +: 8]);
            exp_tx_tag.push_back(tag);
        end
    endtask

    task automatic expect_bus(input logic we, input logic [15:0] a, input logic [31:0] wd,
                              input logic [31:0] rd, input string tag);
        exp_we.push_back(we);
        exp_addr.push_back(a);
        exp_wd.push_back(wd);
        exp_rd.push_back(rd);
        exp_bus_tag.push_back(tag);
    endtask

    task automatic send(input logic [71:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_data  = v[(n - 1 - i) * 8 +: 8];
            rx_valid = 1'b1;
            @(negedge clk);
            rx_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_tx.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // Transmit readiness driver
    initial begin
        tx_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (ready_mode)
                1:       tx_ready = lfsr[0];
                2:       tx_ready = 1'b0;
                default: tx_ready = 1'b1;
            endcase
        end
    end

    // Monitor: compares every reply byte handshake with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL %s unexpected reply byte: actual=%0h expected=none", cur_tag, tx_data);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_tx.pop_front();
                    t = exp_tx_tag.pop_front();
                    check(t, 64'(tx_data), 64'(e), "reply byte");
                end
            end
        end
    end

    // Bus responder and access checker
    initial begin
        int waited;
        waited    = 0;
        bus_ready = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_ready) begin
                bus_ready = 1'b0;
            end else if (rst_n && bus_cs) begin
                if (waited == bus_lat) begin
                    waited = 0;
                    bus_seen++;
                    if (exp_we.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL %s unexpected bus access: actual=%0h expected=none", cur_tag, bus_addr);
                    end else begin
                        logic        we;
                        logic [15:0] a;
                        logic [31:0] wd, rd;
                        string       t;
                        we = exp_we.pop_front();
                        a  = exp_addr.pop_front();
                        wd = exp_wd.pop_front();
                        rd = exp_rd.pop_front();
                        t  = exp_bus_tag.pop_front();
                        check(t, 64'(bus_we), 64'(we), "bus_we");
                        check(t, 64'(bus_addr), 64'(a), "bus_addr");
                        if (we) check(t, 64'(bus_wdata), 64'(wd), "bus_wdata");
                        bus_rdata = rd;
                    end
                    bus_ready = 1'b1;
                end else begin
                    waited++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog: actual=hung expected=complete", cur_tag);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seen0;
        rst_n    = 1'b0;
        rx_valid = 1'b0;
        rx_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check("R11", 64'(bus_cs), 64'd0, "bus_cs after reset");
        check("R11", 64'(tx_valid), 64'd0, "tx_valid after reset");
        check("R11", 64'(soft_rst), 64'd0, "soft_rst after reset");

        // R1: stray bytes while idle
        cur_tag = "R1";
        send(72'h12_AA_07, 3);
        repeat (10) @(negedge clk);
        check("R1", 64'(bus_seen), 64'd0, "bus accesses after stray bytes");
        check("R1", 64'(tx_valid), 64'd0, "tx_valid after stray bytes");

        // R2 / R3: read with immediate ready
        cur_tag = "R2";
        bus_lat = 0;
        expect_bus(1'b0, 16'h2009, 32'h0, 32'hDEADBEEF, "R2");
        expect_tx(72'hAA_7F_20_09_DE_AD_BE_EF_55, 9, "R3");
        send(72'h55_10_20_09_AA, 5);
        check("R2", 64'(bus_cs), 64'd1, "bus_cs one cycle after end byte");
        check("R2", 64'(bus_we), 64'd0, "bus_we on read");
        drain();

        // R4: writes with a delayed bus
        cur_tag = "R4";
        bus_lat = 2;
        expect_bus(1'b1, 16'h101F, 32'h00000018, 32'h0, "R4");
        expect_tx(72'hAA_7E_10_1F_55, 5, "R4");
        send(72'h55_11_10_1F_00_00_00_18_AA, 9);
        drain();
        expect_bus(1'b1, 16'hA55A, 32'h12345678, 32'h0, "R4");
        expect_tx(72'hAA_7E_A5_5A_55, 5, "R4");
        send(72'h55_11_A5_5A_12_34_56_78_AA, 9);
        drain();

        // R5: slow bus holds the request and delays the reply
        cur_tag = "R5";
        bus_lat = 5;
        expect_bus(1'b0, 16'h0324, 32'h0, 32'h0BADF00D, "R5");
        expect_tx(72'hAA_7F_03_24_0B_AD_F0_0D_55, 9, "R5");
        send(72'h55_10_03_24_AA, 5);
        for (int i = 0; i < 4; i++) begin
            check("R5", 64'({bus_cs, tx_valid}), 64'b10, "request held, no reply");
            check("R5", 64'(bus_addr), 64'h0324, "bus_addr held");
            @(negedge clk);
        end
        drain();
        bus_lat = 0;

        // R6: bad end marker
        cur_tag = "R6";
        seen0 = bus_seen;
        expect_tx(72'hAA_FD_55, 3, "R6");
        send(72'h55_10_00_01_33, 5);
        drain();
        expect_tx(72'hAA_FD_55, 3, "R6");
        send(72'h55_01_77, 3);
        drain();
        expect_tx(72'hAA_FD_55, 3, "R6");
        send(72'h55_11_00_01_11_22_33_44_00, 9);
        drain();
        check("R6", 64'(bus_seen), 64'(seen0), "no bus access on bad frame");

        // R7: unknown opcode
        cur_tag = "R7";
        expect_tx(72'hAA_FE_55, 3, "R7");
        send(72'h55_42_01_02_AA, 5);
        drain();
        check("R7", 64'(bus_seen), 64'(seen0), "no bus access on unknown opcode");

        // R8: reset command
        cur_tag = "R8";
        expect_tx(72'hAA_7D_55, 3, "R8");
        send(72'h55_01_AA, 3);
        check("R8", 64'(soft_rst), 64'd1, "soft_rst pulse");
        @(negedge clk);
        check("R8", 64'(soft_rst), 64'd0, "soft_rst single cycle");
        drain();
        check("R8", 64'(bus_seen), 64'(seen0), "no bus access on reset");

        // R9: irregular readiness
        cur_tag = "R9";
        ready_mode = 1;
        expect_bus(1'b0, 16'h7E01, 32'h0, 32'hC0FFEE11, "R9");
        expect_tx(72'hAA_7F_7E_01_C0_FF_EE_11_55, 9, "R9");
        send(72'h55_10_7E_01_AA, 5);
        drain();
        expect_bus(1'b1, 16'h0055, 32'hAA55AA55, 32'h0, "R9");
        expect_tx(72'hAA_7E_00_55_55, 5, "R9");
        send(72'h55_11_00_55_AA_55_AA_55_AA, 9);
        drain();

        // R9: full stall holds the first byte
        ready_mode = 2;
        repeat (2) @(negedge clk);
        expect_bus(1'b0, 16'h0001, 32'h0, 32'h01020304, "R9");
        expect_tx(72'hAA_7F_00_01_01_02_03_04_55, 9, "R9");
        send(72'h55_10_00_01_AA, 5);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R9", 64'({tx_valid, tx_data}), 64'h1AA, "byte held while stalled");
            @(negedge clk);
        end

        // R10: a full frame arriving during the stalled reply is ignored
        cur_tag = "R10";
        seen0 = bus_seen;
        send(72'h55_11_77_77_01_02_03_04_AA, 9);
        check("R10", 64'(bus_seen), 64'(seen0), "no access from ignored frame");
        ready_mode = 0;
        drain();
        repeat (20) @(negedge clk);
        check("R10", 64'(bus_seen), 64'(seen0), "no access after reply drained");
        check("R10", 64'(tx_valid), 64'd0, "no extra reply");
        expect_bus(1'b0, 16'h4242, 32'h0, 32'h89ABCDEF, "R10");
        expect_tx(72'hAA_7F_42_42_89_AB_CD_EF_55, 9, "R10");
        send(72'h55_10_42_42_AA, 5);
        drain();

        check("R10", 64'(exp_tx.size()), 64'd0, "reply queue empty");
        check("R10", 64'(exp_we.size()), 64'd0, "bus queue empty");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule